// File: doc/BRIEF.md
# Daisy-Chain Serial Configuration Receiver

This block receives a serial configuration stream one bit per configuration clock and shares that stream with further devices on a daisy chain. While idle it treats a run of ones as line idle. A four-bit preamble marks the start of a header. The header carries a 24-bit length count, which gives the total number of configuration clocks for the whole chain. The whole header is forwarded downstream unchanged.

The receiver then absorbs its own frames. During this time the chain output is forced high, so that devices further down never see a frame start bit. Each frame is checked for a correct start field and a correct trailing error field. A bad field halts loading for good and drives the open-drain init line low. After the last frame the chain output follows the input again, so the rest of the stream reaches the next device.

A clock-rate select bit is taken from a fixed data position in the first frame. A done flag rises when the length count has been reached, and a finish flag rises four clocks later.

Top module: `cfgl_loader`

## Requirements
- R1: After reset, chain_dout is 1, and init_low, fast_sel, done_load and finish are all 0.
- R2: While hunting, any run of ones is treated as idle. The bit pattern 0,0,1,0 (oldest bit first) arms length capture. Every bit received before and including the preamble appears on chain_dout one clock after it is received.
- R3: The 24 bits that follow the preamble, most significant bit first, become len_count. They are also forwarded on chain_dout one clock later without change.
- R4: Each bit that belongs to this device's frames makes chain_dout 1 one clock later, whatever its value.
- R5: A frame is a start bit of 0, then FRAME_BITS data bits, then an error field of 1,1. The device takes exactly NUM_FRAMES such frames, and init_low stays 0 when all of them are well formed.
- R6: A start bit of 1, or a 0 in the error field, halts loading. From the next clock on, init_low is 1 and chain_dout is 1 permanently. All later input is ignored: done_load and fast_sel no longer change.
- R7: From the bit after the last frame's error field, chain_dout equals cfg_din delayed by one clock.
- R8: Data bit RATE_POS (0-based, counted after the start bit) of the first frame sets fast_sel. fast_sel stays 0 until that bit has been received, and data in later frames does not change it.
- R9: done_load rises one clock after the bit that brings the count of received bits to len_count. Bits are counted from the first preamble bit inclusive, and idle ones before the preamble do not count. Once set, done_load stays high.
- R10: finish rises exactly four clocks after done_load rises, and is never high while done_load is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, one stream bit per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_din | input | 1 | Serial configuration data |
| chain_dout | output | 1 | Serial data to the next device in the chain |
| init_low | output | 1 | Drive-low request for the open-drain init line |
| fast_sel | output | 1 | Selects the eight-times-faster configuration clock |
| len_count | output | LEN_W | Captured length count |
| done_load | output | 1 | Length count reached |
| finish | output | 1 | Four extra clocks have passed after done_load |

## Verification
Two events can fall on the same clock edge: the length count can be reached on the bit that closes the last frame. That edge then both raises done_load and switches chain_dout from forced-high back to pass-through. One run sets the length count to exactly preamble plus header plus frames to provoke this. It then checks that done_load is high right after that error-field bit and that the following bit already appears unmodified on chain_dout. Separate runs break a start bit and an error field. These runs confirm that a halt reached before the length count suppresses done_load and freezes fast_sel.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
   typedef enum logic [2:0] {
      PH_HUNT  = 3'd0,
      PH_LEN   = 3'd1,
      PH_FRAME = 3'd2,
      PH_PASS  = 3'd3,
      PH_HALT  = 3'd4
   } phase_t;
endpackage

// File: rtl/cfgl_hdr.sv
module cfgl_hdr #(
   parameter int             LEN_W    = 24,
   parameter int             PRE_W    = 4,
   parameter logic [PRE_W-1:0] PREAMBLE = 4'b0010
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic             hunt,
   input  logic             len_en,
   output logic             pre_hit,
   output logic             len_last,
   output logic [LEN_W-1:0] len_q
);
   localparam int CNT_W = $clog2(LEN_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LEN_W - 1);

   logic [PRE_W-2:0] hist_q;
   logic [PRE_W-1:0] window;
   logic [CNT_W-1:0] lcnt_q;

   // newest bit sits in the LSB, so the window reads oldest-first from MSB
   assign window   = {hist_q, din};
   assign pre_hit  = hunt && (window == PREAMBLE);
   assign len_last = len_en && (lcnt_q == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '1;
         lcnt_q <= '0;
         len_q  <= '0;
      end else begin
         if (hunt) hist_q <= window[PRE_W-2:0];
         if (pre_hit) lcnt_q <= '0;
         else if (len_en) lcnt_q <= lcnt_q + 1'b1;
         if (len_en) len_q <= {len_q[LEN_W-2:0], din};
      end
   end

   AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !len_en |=> $stable(len_q)); // R3
endmodule

// File: rtl/cfgl_frame.sv
module cfgl_frame #(
   parameter int FRAME_BITS = 64,
   parameter int NUM_FRAMES = 16,
   parameter int RATE_POS   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic en,
   output logic err,
   output logic last_ok,
   output logic rate_q
);
   localparam int POS_W = $clog2(FRAME_BITS + 3);
   localparam int IDX_W = $clog2(NUM_FRAMES + 1);
   localparam logic [POS_W-1:0] POS_DATA_END = POS_W'(FRAME_BITS);
   localparam logic [POS_W-1:0] POS_END      = POS_W'(FRAME_BITS + 2);
   localparam logic [POS_W-1:0] POS_RATE     = POS_W'(RATE_POS + 1);
   localparam logic [IDX_W-1:0] IDX_LAST     = IDX_W'(NUM_FRAMES - 1);

   logic [POS_W-1:0] pos_q;
   logic [IDX_W-1:0] idx_q;

   // position 0 is the start bit, 1..FRAME_BITS data, then two error bits
   assign err = en && (((pos_q == '0) && din) ||
                       ((pos_q > POS_DATA_END) && !din));
   assign last_ok = en && !err && (pos_q == POS_END) && (idx_q == IDX_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         idx_q  <= '0;
         rate_q <= 1'b0;
      end else if (en) begin
         if (pos_q == POS_END) begin
            pos_q <= '0;
            idx_q <= idx_q + 1'b1;
         end else begin
            pos_q <= pos_q + 1'b1;
         end
         if ((idx_q == '0) && (pos_q == POS_RATE)) rate_q <= din;
      end
   end

   AST_RATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_q != '0) |=> $stable(rate_q)); // R8
endmodule

// File: rtl/cfgl_track.sv
module cfgl_track #(
   parameter int LEN_W = 24,
   parameter int PRE_W = 4,
   parameter int TAIL  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic             len_ok,
   input  logic [LEN_W-1:0] len_val,
   output logic             done,
   output logic             finish
);
   localparam int CNT_W  = LEN_W + 1;
   localparam int TAIL_W = $clog2(TAIL + 1);
   localparam logic [TAIL_W-1:0] TAIL_END = TAIL_W'(TAIL);

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_nxt;
   logic [TAIL_W-1:0] tail_q;

   assign cnt_nxt = cnt_q + 1'b1;
   assign finish  = (tail_q == TAIL_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done   <= 1'b0;
         tail_q <= '0;
      end else begin
         if (start) cnt_q <= CNT_W'(PRE_W);
         else if (run) cnt_q <= cnt_nxt;
         if (run && len_ok && !done && (cnt_nxt == {1'b0, len_val})) done <= 1'b1;
         if (done && (tail_q != TAIL_END)) tail_q <= tail_q + 1'b1;
      end
   end

   AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done); // R9
   AST_FINISH_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      finish |-> done); // R10
endmodule

// File: rtl/cfgl_loader.sv
module cfgl_loader
   import cfgl_pkg::*;
#(
   parameter int               LEN_W      = 24,
   parameter int               PRE_W      = 4,
   parameter logic [PRE_W-1:0] PREAMBLE   = 4'b0010,
   parameter int               FRAME_BITS = 64,
   parameter int               NUM_FRAMES = 16,
   parameter int               RATE_POS   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_din,
   output logic             chain_dout,
   output logic             init_low,
   output logic             fast_sel,
   output logic [LEN_W-1:0] len_count,
   output logic             done_load,
   output logic             finish
);
   localparam int TAIL_CLKS = 4;

   if (LEN_W < 2) begin : g_bad_len
      $error("LEN_W must be at least 2");
   end
   if (PRE_W < 2) begin : g_bad_pre
      $error("PRE_W must be at least 2");
   end
   if (PREAMBLE == {PRE_W{1'b1}}) begin : g_bad_pattern
      $error("PREAMBLE must not be all ones, ones are idle");
   end
   if (FRAME_BITS < 1 || NUM_FRAMES < 1) begin : g_bad_frame
      $error("FRAME_BITS and NUM_FRAMES must be positive");
   end
   if (RATE_POS < 0 || RATE_POS >= FRAME_BITS) begin : g_bad_rate
      $error("RATE_POS must index a data bit of the frame");
   end

   phase_t phase_q, phase_d;
   logic   pre_hit, len_last, frm_err, frm_last;
   logic   in_hunt, in_len, in_frame, masking, counting, len_known;

   assign in_hunt   = (phase_q == PH_HUNT);
   assign in_len    = (phase_q == PH_LEN);
   assign in_frame  = (phase_q == PH_FRAME);
   assign masking   = in_frame || (phase_q == PH_HALT);
   assign len_known = in_frame || (phase_q == PH_PASS);
   assign counting  = in_len || len_known;

   cfgl_hdr #(.LEN_W(LEN_W), .PRE_W(PRE_W), .PREAMBLE(PREAMBLE)) u_hdr (
      .clk(clk), .rst_n(rst_n), .din(cfg_din), .hunt(in_hunt), .len_en(in_len),
      .pre_hit(pre_hit), .len_last(len_last), .len_q(len_count));

   cfgl_frame #(.FRAME_BITS(FRAME_BITS), .NUM_FRAMES(NUM_FRAMES), .RATE_POS(RATE_POS)) u_frame (
      .clk(clk), .rst_n(rst_n), .din(cfg_din), .en(in_frame),
      .err(frm_err), .last_ok(frm_last), .rate_q(fast_sel));

   cfgl_track #(.LEN_W(LEN_W), .PRE_W(PRE_W), .TAIL(TAIL_CLKS)) u_track (
      .clk(clk), .rst_n(rst_n), .start(pre_hit), .run(counting), .len_ok(len_known),
      .len_val(len_count), .done(done_load), .finish(finish));

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_HUNT:  if (pre_hit) phase_d = PH_LEN;
         PH_LEN:   if (len_last) phase_d = PH_FRAME;
         PH_FRAME: begin
            if (frm_err) phase_d = PH_HALT;
            else if (frm_last) phase_d = PH_PASS;
         end
         PH_PASS:  phase_d = PH_PASS;
         PH_HALT:  phase_d = PH_HALT;
         default:  phase_d = PH_HALT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_HUNT;
         chain_dout <= 1'b1;
         init_low   <= 1'b0;
      end else begin
         phase_q    <= phase_d;
         chain_dout <= masking ? 1'b1 : cfg_din;
         init_low   <= init_low || (in_frame && frm_err);
      end
   end

   AST_FRAME_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      in_frame |=> chain_dout); // R4
   AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_PASS) |=> (chain_dout == $past(cfg_din))); // R7
   AST_HALT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      init_low |=> (init_low && chain_dout)); // R6
   AST_HALT_RATE: assert property (@(posedge clk) disable iff (!rst_n)
      init_low |=> $stable(fast_sel)); // R6
endmodule

// File: tb/sim_cfgl_loader.sv
`timescale 1ns/1ps
module sim_cfgl_loader;
   localparam int LEN_W = 24;
   localparam int FB    = 6;
   localparam int NF    = 3;
   localparam int RP    = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_din = 1'b1;
   logic chain_dout, init_low, fast_sel, done_load, finish;
   logic [LEN_W-1:0] len_count;

   int n_chk = 0;
   int n_bad = 0;
   bit ended = 0;
   logic  exp_q[$];
   string tag_q[$];

   always #10 clk = ~clk;

   cfgl_loader #(.LEN_W(LEN_W), .FRAME_BITS(FB), .NUM_FRAMES(NF), .RATE_POS(RP)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_din(cfg_din), .chain_dout(chain_dout),
      .init_low(init_low), .fast_sel(fast_sel), .len_count(len_count),
      .done_load(done_load), .finish(finish));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // monitor: pops the expected chain bit for the bit driven before this edge
   always begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
         logic  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(t, {31'd0, chain_dout}, {31'd0, e});
      end
   end

   task automatic send_bit(input logic b, input logic e, input string t);
      @(negedge clk);
      cfg_din = b;
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic hdr_bit(input logic b);
      send_bit(b, b, "R2/R3 header forward");
   endtask

   task automatic frm_bit(input logic b);
      send_bit(b, 1'b1, "R4 frame mask");
   endtask

   task automatic pass_bit(input logic b);
      send_bit(b, b, "R7 pass through");
   endtask

   task automatic settle();
      @(posedge clk);
      #3;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cfg_din = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic send_header(input int idle, input logic [LEN_W-1:0] len);
      for (int i = 0; i < idle; i++) hdr_bit(1'b1);
      hdr_bit(1'b0); hdr_bit(1'b0); hdr_bit(1'b1); hdr_bit(1'b0);
      for (int i = LEN_W - 1; i >= 0; i--) hdr_bit(len[i]);
      settle();
      chk("R3 length count", {8'd0, len_count}, {8'd0, len});
   endtask

   task automatic send_frame(input logic [FB-1:0] d);
      frm_bit(1'b0);
      for (int k = 0; k < FB; k++) frm_bit(d[k]);
      frm_bit(1'b1); frm_bit(1'b1);
   endtask

   initial begin
      #4_000_000;
      if (!ended) begin
         ended = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      // ---- run A: good load, length 65 = 4 + 24 + 27 + 10
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      settle();
      chk("R1 dout after reset", {31'd0, chain_dout}, 32'd1);
      chk("R1 init_low after reset", {31'd0, init_low}, 32'd0);
      chk("R1 fast_sel after reset", {31'd0, fast_sel}, 32'd0);
      chk("R1 done after reset", {31'd0, done_load}, 32'd0);
      chk("R1 finish after reset", {31'd0, finish}, 32'd0);
      send_header(3, 24'd65);
      frm_bit(1'b0);
      frm_bit(1'b0);
      settle();
      chk("R8 slow until rate bit", {31'd0, fast_sel}, 32'd0);
      frm_bit(1'b1);
      settle();
      chk("R8 rate bit taken", {31'd0, fast_sel}, 32'd1);
      for (int k = 2; k < FB; k++) frm_bit(k[0]);
      frm_bit(1'b1); frm_bit(1'b1);
      send_frame(6'b110101);
      send_frame(6'b000000);
      settle();
      chk("R8 later frame ignored", {31'd0, fast_sel}, 32'd1);
      chk("R5 good frames accepted", {31'd0, init_low}, 32'd0);
      for (int i = 0; i < 9; i++) pass_bit(i[0] ^ i[2]);
      settle();
      chk("R9 not done at bit 64", {31'd0, done_load}, 32'd0);
      pass_bit(1'b0);
      settle();
      chk("R9 done at bit 65", {31'd0, done_load}, 32'd1);
      for (int i = 0; i < 3; i++) pass_bit(i[0]);
      settle();
      chk("R10 finish not yet", {31'd0, finish}, 32'd0);
      pass_bit(1'b1);
      settle();
      chk("R10 finish after four", {31'd0, finish}, 32'd1);
      chk("R9 done held", {31'd0, done_load}, 32'd1);

      // ---- run B: start bit error in frame 1, length 40
      do_reset();
      send_header(2, 24'd40);
      send_frame(6'b000010);
      frm_bit(1'b1);
      settle();
      chk("R6 init low on start error", {31'd0, init_low}, 32'd1);
      for (int i = 0; i < 20; i++) send_bit(i[0], 1'b1, "R6 halted dout high");
      settle();
      chk("R6 done suppressed", {31'd0, done_load}, 32'd0);
      chk("R6 fast_sel frozen", {31'd0, fast_sel}, 32'd1);

      // ---- run C: error field 1,0 in frame 0
      do_reset();
      send_header(0, 24'd60);
      frm_bit(1'b0);
      for (int k = 0; k < FB; k++) frm_bit(1'b0);
      frm_bit(1'b1);
      settle();
      chk("R5 no halt mid error field", {31'd0, init_low}, 32'd0);
      frm_bit(1'b0);
      settle();
      chk("R6 init low on error field", {31'd0, init_low}, 32'd1);
      for (int i = 0; i < 12; i++) send_bit(1'b1, 1'b1, "R6 halted dout high");
      settle();
      chk("R6 fast_sel stays slow", {31'd0, fast_sel}, 32'd0);

      // ---- run D: length reached on the last error bit (4+24+27 = 55)
      do_reset();
      send_header(1, 24'd55);
      send_frame(6'b111101);
      send_frame(6'b101010);
      send_frame(6'b010101);
      settle();
      chk("R9 done with last frame bit", {31'd0, done_load}, 32'd1);
      chk("R8 rate bit zero", {31'd0, fast_sel}, 32'd0);
      pass_bit(1'b0); pass_bit(1'b1); pass_bit(1'b0);
      settle();
      chk("R7 init quiet in pass", {31'd0, init_low}, 32'd0);
      pass_bit(1'b1);
      settle();
      chk("R10 finish on coincident run", {31'd0, finish}, 32'd1);
      settle();

      if (!ended) begin
         ended = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule